// File: doc/BRIEF.md
# Configuration status readback master

This block is the master side of a byte-wide parallel configuration port. A single request reads back the device's 32-bit configuration status word, and afterwards the port is left usable for more reads or for reconfiguration. The master makes the configuration clock from the system clock with a programmable divider. It drives chip-select, read/write select and the outgoing byte lane with its output enable, and it watches the busy line and the incoming byte lane. The bidirectional pad is split at the block edge into separate in, out and enable signals.

A pulse on `start_i` runs one complete session:

1. **Command phase.** Write a dummy word, the sync word, a no-op, a one-word read request for the status register, and two no-ops.
2. **First turnaround.** Raise chip-select and switch the bus to read in the same configuration-clock step. Hold chip-select high for one clock, then lower it again.
3. **Read phase.** Keep clocking while busy is high. Take a byte on each clock where busy is low until four bytes are held.
4. **Second turnaround.** Switch the bus back to write the same way.
5. **Closing phase.** Write a command-register write, the desynchronise code and two no-ops, then release chip-select.

When the session ends, `done_o` pulses and `status_o` carries the assembled word. If busy stays high too long, the read is abandoned and a timeout flag is raised. The closing desynchronise sequence is still written, so the port is never left stuck.

Top module: `cfg_readback_master`

## Requirements
- R1: While a session runs, `cclk_o` toggles every `div_i`+1 system clocks. When idle, `cclk_o` is low, `cs_n_o` is high and `data_oe_o` is low. Pins change only while `cclk_o` is low, and each rising edge of `cclk_o` is the sampling point.
- R2: The command phase writes these words with `cs_n_o`=0 and `rdwr_n_o`=0 (0 means write), most significant byte first, one byte per rising edge: FFFFFFFF, AA995566, 20000000, 2800E001, 20000000, 20000000.
- R3: Each turnaround happens in two steps:
  - In one step, `cs_n_o` goes high and `rdwr_n_o` changes, with no rising `cclk_o` edge between the two changes.
  - Then exactly one rising edge passes with `cs_n_o` high before `cs_n_o` goes low again.
  
  In total, 40 bytes are written per session with no extra or missing byte.
- R4: In the read phase (`rdwr_n_o`=1, `cs_n_o`=0), a byte is taken only on a rising edge where `busy_i` is low. Four bytes are taken, and the first one becomes bits 31:24 of the status word.
- R5: The closing phase writes 30008001, 0000000D, 20000000 and 20000000, most significant byte first, and then raises `cs_n_o`. In the same cycle, `done_o` pulses for exactly one system clock and `status_o` is updated.
- R6: `data_oe_o` is high only while `rdwr_n_o` is 0. It is low in both turnaround steps and in the read phase.
- R7: With `BIT_SWAP`=1, bus bit i carries bit 7-i of the logical byte. This applies to both `data_o` and `data_i`.
- R8: The read fails when `busy_i` is high on more than `busy_limit_i` consecutive read edges. In that case:
  - `timeout_o` is set and held until the next start.
  - The closing phase is still written.
  - `status_o` keeps its previous value.
  
  Exactly `busy_limit_i` busy edges raise no error.
- R9: Sessions can be repeated back to back, and each one produces the full sequence. A `start_i` pulse during a session has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start one readback session (taken while idle) |
| div_i | input | DIV_W | Half-period of the configuration clock minus one, in system clocks; held stable during a session |
| busy_limit_i | input | BUSY_W | Largest allowed run of busy read edges |
| done_o | output | 1 | One-cycle pulse at session end |
| status_o | output | 32 | Last status word read successfully |
| timeout_o | output | 1 | Busy timeout occurred in the last session |
| cclk_o | output | 1 | Configuration clock |
| cs_n_o | output | 1 | Chip-select, active low |
| rdwr_n_o | output | 1 | Read/write select, 1 means read |
| data_o | output | 8 | Outgoing byte lane |
| data_oe_o | output | 1 | Output enable for the byte lane |
| data_i | input | 8 | Incoming byte lane |
| busy_i | input | 1 | Busy from the port |

## Verification
- **Pin changes.** Chip-select, read/write select and the byte lane move in the system cycle where `cclk_o` falls. Each value is therefore seen at the next rising edge of `cclk_o`, `div_i`+1 system clocks later. The bench's port model samples exactly at those rising edges, and its responder updates busy and data 1 ns after each falling edge.
- **Session results.** `done_o`, `status_o` and `timeout_o` are due in the same system cycle, the one in which the final falling edge of `cclk_o` lands. The bench samples them at the falling system edge of that cycle, then checks that `done_o` is low one cycle later.
- **Every-cycle checks.** On every system clock the bench checks the half-period count, the enable-versus-direction rule and the idle pin state.

// File: rtl/cfg_rb_pkg.sv
package cfg_rb_pkg;

    localparam int IDX_W       = 6;
    localparam int WORD_W      = 32;
    localparam int HDR_LAST    = 23;
    localparam int CLOSE_FIRST = 24;
    localparam int CLOSE_LAST  = 39;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_TURN_R,
        PH_READ,
        PH_TURN_W,
        PH_CLOSE
    } phase_t;

    // word slot -> 32-bit command word (slots 0..5 header, 6..9 closing)
    function automatic logic [WORD_W-1:0] cmd_word(input logic [3:0] slot);
        case (slot)
            4'd0:    cmd_word = 32'hFFFF_FFFF;
            4'd1:    cmd_word = 32'hAA99_5566;
            4'd3:    cmd_word = 32'h2800_E001;
            4'd6:    cmd_word = 32'h3000_8001;
            4'd7:    cmd_word = 32'h0000_000D;
            default: cmd_word = 32'h2000_0000;
        endcase
    endfunction

    function automatic logic [7:0] bit_rev(input logic [7:0] b);
        for (int i = 0; i < 8; i++) bit_rev[i] = b[7-i];
    endfunction

endpackage

// File: rtl/cfg_cclk_div.sv
module cfg_cclk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             cclk_o,
    output logic             rise_o,
    output logic             fall_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             cclk;
    } div_st_t;

    div_st_t s_d, s_q;
    logic    edge_w;

    assign edge_w = run_i && (s_q.cnt == div_i);
    assign rise_o = edge_w && !s_q.cclk;
    assign fall_o = edge_w &&  s_q.cclk;
    assign cclk_o = s_q.cclk;

    always_comb begin
        s_d = s_q;
        if (!run_i) begin
            s_d.cnt  = '0;
            s_d.cclk = 1'b0;
        end else if (edge_w) begin
            s_d.cnt  = '0;
            s_d.cclk = ~s_q.cclk;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R1
    rise_only_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> cclk_o);

endmodule

// File: rtl/cfg_cmd_bytes.sv
module cfg_cmd_bytes
    import cfg_rb_pkg::*;
#(
    parameter bit BIT_SWAP = 1'b1
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [7:0]       byte_o
);
    logic [WORD_W-1:0] word_w;
    logic [WORD_W-1:0] shifted_w;
    logic [7:0]        raw_w;

    always_comb begin
        word_w    = cmd_word(idx_i[5:2]);
        shifted_w = word_w >> {~idx_i[1:0], 3'b000};
        raw_w     = shifted_w[7:0];
    end

    generate
        if (BIT_SWAP) begin : g_swap
            for (genvar i = 0; i < 8; i++) begin : g_bit
                assign byte_o[i] = raw_w[7-i];
            end
        end else begin : g_straight
            assign byte_o = raw_w;
        end
    endgenerate

endmodule

// File: rtl/cfg_readback_master.sv
module cfg_readback_master
    import cfg_rb_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int BUSY_W   = 16,
    parameter bit BIT_SWAP = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [BUSY_W-1:0] busy_limit_i,
    output logic              done_o,
    output logic [31:0]       status_o,
    output logic              timeout_o,
    output logic              cclk_o,
    output logic              cs_n_o,
    output logic              rdwr_n_o,
    output logic [7:0]        data_o,
    output logic              data_oe_o,
    input  logic [7:0]        data_i,
    input  logic              busy_i
);
    typedef struct packed {
        phase_t            phase;
        logic [IDX_W-1:0]  idx;
        logic [1:0]        rd_cnt;
        logic              full;
        logic [BUSY_W-1:0] busy_cnt;
        logic [WORD_W-1:0] shift;
        logic [WORD_W-1:0] status;
        logic              err;
        logic              done;
        logic              cs_n;
        logic              rdwr_n;
        logic              oe;
        logic              run;
    } mst_st_t;

    mst_st_t    s_d, s_q;
    logic       rise_w, fall_w;
    logic [7:0] din_w;

    cfg_cclk_div #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (s_q.run),
        .div_i  (div_i),
        .cclk_o (cclk_o),
        .rise_o (rise_w),
        .fall_o (fall_w)
    );

    cfg_cmd_bytes #(.BIT_SWAP(BIT_SWAP)) u_cmd (
        .idx_i  (s_q.idx),
        .byte_o (data_o)
    );

    generate
        if (BIT_SWAP) begin : g_in_swap
            assign din_w = bit_rev(data_i);
        end else begin : g_in_straight
            assign din_w = data_i;
        end
    endgenerate

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    s_d.phase    = PH_CMD;
                    s_d.idx      = '0;
                    s_d.rd_cnt   = '0;
                    s_d.full     = 1'b0;
                    s_d.busy_cnt = '0;
                    s_d.err      = 1'b0;
                    s_d.cs_n     = 1'b0;
                    s_d.rdwr_n   = 1'b0;
                    s_d.oe       = 1'b1;
                    s_d.run      = 1'b1;
                end
            end
            PH_CMD: begin
                if (fall_w) begin
                    if (s_q.idx == IDX_W'(HDR_LAST)) begin
                        s_d.phase  = PH_TURN_R;
                        s_d.cs_n   = 1'b1;
                        s_d.rdwr_n = 1'b1;
                        s_d.oe     = 1'b0;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            PH_TURN_R: begin
                if (fall_w) begin
                    s_d.phase = PH_READ;
                    s_d.cs_n  = 1'b0;
                end
            end
            PH_READ: begin
                if (rise_w && !s_q.full && !s_q.err) begin
                    if (!busy_i) begin
                        s_d.shift    = {s_q.shift[WORD_W-9:0], din_w};
                        s_d.rd_cnt   = s_q.rd_cnt + 1'b1;
                        s_d.full     = (s_q.rd_cnt == 2'd3);
                        s_d.busy_cnt = '0;
                    end else if (s_q.busy_cnt >= busy_limit_i) begin
                        s_d.err = 1'b1;
                    end else begin
                        s_d.busy_cnt = s_q.busy_cnt + 1'b1;
                    end
                end
                if (fall_w && (s_q.full || s_q.err)) begin
                    s_d.phase  = PH_TURN_W;
                    s_d.cs_n   = 1'b1;
                    s_d.rdwr_n = 1'b0;
                end
            end
            PH_TURN_W: begin
                if (fall_w) begin
                    s_d.phase = PH_CLOSE;
                    s_d.cs_n  = 1'b0;
                    s_d.oe    = 1'b1;
                    s_d.idx   = IDX_W'(CLOSE_FIRST);
                end
            end
            PH_CLOSE: begin
                if (fall_w) begin
                    if (s_q.idx == IDX_W'(CLOSE_LAST)) begin
                        s_d.phase = PH_IDLE;
                        s_d.cs_n  = 1'b1;
                        s_d.oe    = 1'b0;
                        s_d.run   = 1'b0;
                        s_d.done  = 1'b1;
                        if (!s_q.err) s_d.status = s_q.shift;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.phase  <= PH_IDLE;
            s_q.cs_n   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign done_o    = s_q.done;
    assign status_o  = s_q.status;
    assign timeout_o = s_q.err;
    assign cs_n_o    = s_q.cs_n;
    assign rdwr_n_o  = s_q.rdwr_n;
    assign data_oe_o = s_q.oe;

    // R6
    oe_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> !rdwr_n_o);

    // R3
    dir_change_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdwr_n_o) |-> cs_n_o);

    // R1
    pins_move_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cs_n_o) |-> !cclk_o);

    // R5
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    status_kept_on_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && timeout_o) |-> $stable(status_o));

endmodule

// File: tb/cfg_readback_master_test.sv
`timescale 1ns/1ps
module cfg_readback_master_test;
    localparam int DIV_W  = 8;
    localparam int BUSY_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [DIV_W-1:0]  div_i = '0;
    logic [BUSY_W-1:0] busy_limit_i = '0;
    logic              done_o, timeout_o, cclk_o, cs_n_o, rdwr_n_o, data_oe_o;
    logic [31:0]       status_o;
    logic [7:0]        data_o;
    logic [7:0]        data_i = '0;
    logic              busy_i = 1'b0;

    int checks = 0;
    int failures = 0;

    cfg_readback_master #(.DIV_W(DIV_W), .BUSY_W(BUSY_W), .BIT_SWAP(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .div_i(div_i),
        .busy_limit_i(busy_limit_i), .done_o(done_o), .status_o(status_o),
        .timeout_o(timeout_o), .cclk_o(cclk_o), .cs_n_o(cs_n_o),
        .rdwr_n_o(rdwr_n_o), .data_o(data_o), .data_oe_o(data_oe_o),
        .data_i(data_i), .busy_i(busy_i)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    localparam logic [31:0] EXPW [10] = '{32'hFFFF_FFFF, 32'hAA99_5566, 32'h2000_0000,
        32'h2800_E001, 32'h2000_0000, 32'h2000_0000, 32'h3000_8001, 32'h0000_000D,
        32'h2000_0000, 32'h2000_0000};

    // port-side model state
    logic [7:0]  wq[$];
    logic [31:0] dev_word = '0;
    int          dev_lat = 0;
    bit          dev_gap = 0;
    int          rd_edges = 0;
    int          dcnt = 0;
    logic        prev_cs = 1'b1, prev_rd = 1'b0;
    bit          turned = 0;
    int          hi_cnt = 0;
    bit          sess = 0;

    function automatic bit busy_at(input int r);
        return (r < dev_lat) || (dev_gap && r == dev_lat + 2);
    endfunction

    // sampling point: rising configuration clock
    always @(posedge cclk_o) begin
        if (rdwr_n_o !== prev_rd) begin
            check("R3 cs high and direction change share one step", {30'd0, prev_cs, cs_n_o}, 32'h1);
            turned = 1;
        end
        if (cs_n_o) begin
            hi_cnt++;
        end else begin
            if (turned && prev_cs) begin
                check("R3 exactly one cs-high edge in turnaround", hi_cnt, 1);
                turned = 0;
            end
            hi_cnt = 0;
        end
        if (!cs_n_o && !rdwr_n_o) wq.push_back(rev8(data_o));
        if (!cs_n_o && rdwr_n_o) begin
            if (!busy_i) dcnt++;
            rd_edges++;
        end else if (cs_n_o) begin
            rd_edges = 0;
            dcnt = 0;
        end
        prev_cs = cs_n_o;
        prev_rd = rdwr_n_o;
    end

    // responder: busy and data change after the falling edge
    always @(negedge cclk_o) begin
        #1;
        if (!cs_n_o && rdwr_n_o) begin
            busy_i = busy_at(rd_edges);
            data_i = (dcnt < 4) ? rev8(8'(dev_word >> (8*(3-dcnt)))) : 8'h00;
        end else begin
            busy_i = 1'b0;
            data_i = 8'h00;
        end
    end

    // every-cycle reference checks
    int  hp_cnt = 0;
    bit  seen_tog = 0;
    logic prev_c = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (data_oe_o) check("R6 enable only in write direction", {31'd0, rdwr_n_o}, 0);
            if (!sess) begin
                check("R1 idle pins", {29'd0, cclk_o, cs_n_o, data_oe_o}, 32'h2);
                seen_tog = 0;
            end else if (cclk_o !== prev_c) begin
                if (seen_tog) check("R1 half period", hp_cnt, int'(div_i) + 1);
                seen_tog = 1;
                hp_cnt = 1;
            end else begin
                hp_cnt++;
            end
            prev_c = cclk_o;
        end
    end

    logic [31:0] last_status = '0;

    task automatic run_session(input int div, input int limit, input int lat, input bit gap,
                               input logic [31:0] word, input bit exp_err, input bit inject);
        int n;
        @(negedge clk);
        div_i = DIV_W'(div);
        busy_limit_i = BUSY_W'(limit);
        dev_lat = lat;
        dev_gap = gap;
        dev_word = word;
        wq.delete();
        sess = 1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        while (!done_o && n < 20000) begin
            @(negedge clk);
            n++;
            start_i = (inject && n == 150);
        end
        start_i = 1'b0;
        if (!done_o) begin
            failures++;
            checks++;
            $display("FAIL R9 session never finished actual=0 expected=1");
        end
        check(exp_err ? "R8 status unchanged on timeout" : "R4 status word",
              status_o, exp_err ? last_status : word);
        check("R8 timeout flag", {31'd0, timeout_o}, {31'd0, exp_err});
        check("R5 cs released at done", {31'd0, cs_n_o}, 1);
        check("R3 R9 bytes written per session", wq.size(), 40);
        for (int k = 0; k < 40 && k < wq.size(); k++)
            check(k < 24 ? "R2 R7 command byte" : "R5 R7 closing byte", wq[k],
                  {24'd0, 8'(EXPW[k/4] >> (8*(3-(k%4))))});
        if (!exp_err) last_status = word;
        sess = 0;
        @(negedge clk);
        check("R5 done lasts one cycle", {31'd0, done_o}, 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset pins", {28'd0, cclk_o, cs_n_o, data_oe_o, done_o}, 32'h4);
        check("R8 reset flag and status", {status_o[30:0], timeout_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_session(1, 8, 3, 0, 32'h3E5C_A1F0, 0, 0);
        run_session(0, 8, 1, 1, 32'h0000_0001, 0, 0);   // busy gap mid-read, R4
        run_session(9, 5, 5, 0, 32'hF0F0_1234, 0, 1);   // limit boundary R8, start ignored R9
        run_session(2, 4, 20, 0, 32'h1111_2222, 1, 0);  // timeout R8
        run_session(2, 6, 2, 1, 32'hDEAD_BEEF, 0, 0);   // port usable after timeout R9
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 190000);
        failures++;
        checks++;
        $display("FAIL R9 watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule